// File: doc/BRIEF.md
# Multi-Input ADC Step Sequencer

This block drives a single conversion engine across up to eight analog inputs. Each input carries three settings: an enable bit, a settling count measured in converter-clock ticks, and a power-of-two averaging code. A prescaler divides the reference clock to produce the converter tick. While at least one input is enabled, the sequencer visits the enabled inputs from the lowest index to the highest. On reaching an input it selects it and waits out that input's settling count. It then requests conversions until the configured number of samples has arrived, adds them in a wide accumulator, scales the sum down, and writes the 12-bit average into that input's result register.

Each input has exactly one result register and one valid flag. A reader fetches a result by presenting its index with a read strobe. The data comes back in the same cycle, and the valid flag drops one cycle later. If every enable is cleared, the sequencer drops any group in progress, powers the converter down and stops scanning.

Top module: `adc_step_seq`

## Requirements
- R1: After reset the converter is unpowered, `conv_req` is low, every `res_valid` bit is 0, and the prescaler holds 2400, so the tick period is 2400 reference cycles once an input is enabled.
- R2: A prescaler write stores the written value, except that any value below 10 is stored as 10. While the converter is powered, `conv_tick` pulses once every prescaler-value cycles.
- R3: `conv_pwr` is high exactly when the sequencer is not idle. In the cycle after all enables read 0, `conv_pwr` and `conv_req` are low and any partial group is discarded.
- R4: Enabled inputs are visited in ascending index order, skipping disabled ones. After the highest enabled input, the scan returns to the lowest; with a single enabled input, that input repeats.
- R5: Between finishing one input and raising `conv_req` for the next, the sequencer waits exactly that input's settling count of converter ticks. A count of 0 requests at once.
- R6: Averaging code k (3 bits per input, input i at bits 3i+2..3i) takes 2^k samples for k = 0..4; codes 5, 6 and 7 act as 4 (16 samples). The stored result is the sum shifted right by the effective k, truncated.
- R7: Storing a result sets that input's valid flag. With `rd_en` high, `rd_data` shows the result for `rd_idx` in the same cycle, and that valid flag is 0 in the following cycle.
- R8: `conv_sel` stays constant while `conv_req` is high, and `conv_req` stays high until the last `conv_done` of the group.
- R9: Sixteen full-scale samples (4095) average to 4095, with no accumulator overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_en | input | 8 | Per-input enable, bit i for input i |
| cfg_open_dly | input | 64 | Settling counts, 8 bits per input, input i at bits 8i+7..8i |
| cfg_avg | input | 24 | Averaging codes, 3 bits per input |
| presc_wr | input | 1 | Prescaler write strobe |
| presc_val | input | 16 | Prescaler value to write |
| conv_pwr | output | 1 | Converter power enable |
| conv_tick | output | 1 | One-cycle converter clock enable |
| conv_sel | output | 3 | Selected input index |
| conv_req | output | 1 | Conversion request, held until done |
| conv_done | input | 1 | One-cycle completion pulse from the engine |
| conv_data | input | 12 | Sample returned with `conv_done` |
| rd_en | input | 1 | Result read strobe |
| rd_idx | input | 3 | Index of result to read |
| rd_data | output | 12 | Result for `rd_idx` |
| res_valid | output | 8 | Per-input new-result flags |

## Verification
The assertions take two things for granted about the inputs. First, the engine pulses `conv_done` for one cycle, and only while `conv_req` is high. Second, settling and averaging settings change only while every input is disabled. The bench engine model respects both: it answers only a request that is still outstanding, and it abandons its reply if the request drops during its randomized latency. The bench applies every new configuration only after clearing the enables, and it clears them only in a cycle where no completion is in flight. This keeps its own sample accounting in step with the design.

// File: rtl/adc_seq_pkg.sv
// Package: shared state type and averaging-code helpers for the step sequencer.
// Assumes averaging codes are 3 bits wide and at most 16 samples per result.
package adc_seq_pkg;
    localparam int AVG_W     = 3;
    localparam int MAX_SHIFT = 4;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_CONV,
        ST_STORE
    } scan_state_e;

    // Effective right shift for an averaging code; codes above 4 saturate.
    function automatic logic [AVG_W-1:0] avg_shift(input logic [AVG_W-1:0] code);
        return (code > AVG_W'(MAX_SHIFT)) ? AVG_W'(MAX_SHIFT) : code;
    endfunction
endpackage

// File: rtl/adc_clk_div.sv
// Converter clock divider: produces a one-cycle tick every presc_q cycles while run is high.
// Assumes: the stored divisor is never below PRESC_MIN because writes are clamped.
module adc_clk_div #(
    parameter int PRESC_W       = 16,
    parameter int PRESC_DEFAULT = 2400,
    parameter int PRESC_MIN     = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic               wr,
    input  logic [PRESC_W-1:0] wdata,
    output logic               tick
);
    logic [PRESC_W-1:0] presc_q;
    logic [PRESC_W-1:0] cnt_q;
    logic               wrap;

    assign wrap = cnt_q >= (presc_q - PRESC_W'(1));
    assign tick = run && wrap;

    // Divisor register with lower clamp.
    always_ff @(posedge clk) begin
        if (!rst_n)
            presc_q <= PRESC_W'(PRESC_DEFAULT);
        else if (wr)
            presc_q <= (wdata < PRESC_W'(PRESC_MIN)) ? PRESC_W'(PRESC_MIN) : wdata;
    end

    // Free-running divider counter, held at zero while unpowered.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)
            cnt_q <= '0;
        else if (wrap)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + PRESC_W'(1);
    end
endmodule

// File: rtl/adc_scan_ctrl.sv
// Scan controller: picks the next enabled input in ascending order, counts its
// settling ticks, holds the request for a whole group and signals the store.
// Assumes: done only pulses while req is high; settings change only while idle.
module adc_scan_ctrl
    import adc_seq_pkg::*;
#(
    parameter int NUM_IN = 8,
    parameter int DLY_W  = 8,
    localparam int IDX_W = $clog2(NUM_IN)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_IN-1:0]       en,
    input  logic [NUM_IN*DLY_W-1:0] dly_flat,
    input  logic                    tick,
    input  logic                    done,
    input  logic                    grp_last,
    output logic [IDX_W-1:0]        sel,
    output logic                    req,
    output logic                    pwr,
    output logic                    acc_clr,
    output logic                    acc_add,
    output logic                    st_en
);
    scan_state_e        state_q;
    logic [IDX_W-1:0]   cur_q;
    logic [IDX_W-1:0]   nxt;
    logic [DLY_W-1:0]   dly_q;
    logic               any_en;

    assign any_en = |en;

    // Circular search for the next enabled input above the current one.
    always_comb begin
        logic found;
        found = 1'b0;
        nxt   = cur_q;
        for (int k = 1; k <= NUM_IN; k++) begin
            int cand;
            cand = (int'(cur_q) + k) % NUM_IN;
            if (!found && en[cand]) begin
                nxt   = IDX_W'(cand);
                found = 1'b1;
            end
        end
    end

    // Sequencing state, current input and settling counter.
    always_ff @(posedge clk) begin
        if (!rst_n || !any_en) begin
            state_q <= ST_IDLE;
            cur_q   <= IDX_W'(NUM_IN - 1);
            dly_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE, ST_STORE: begin
                    cur_q   <= nxt;
                    dly_q   <= dly_flat[int'(nxt)*DLY_W +: DLY_W];
                    state_q <= ST_SETTLE;
                end
                ST_SETTLE: begin
                    if (dly_q == '0)
                        state_q <= ST_CONV;
                    else if (tick)
                        dly_q <= dly_q - DLY_W'(1);
                end
                ST_CONV: begin
                    if (done && grp_last)
                        state_q <= ST_STORE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign sel     = cur_q;
    assign req     = (state_q == ST_CONV);
    assign pwr     = (state_q != ST_IDLE);
    assign acc_clr = (state_q == ST_SETTLE);
    assign acc_add = req && done;
    assign st_en   = (state_q == ST_STORE);
endmodule

// File: rtl/adc_avg_acc.sv
// Sample averager: sums samples of one group and shifts the sum by the averaging code.
// Assumes: at most 2^MAX_SHIFT samples per group so the sum cannot overflow.
module adc_avg_acc
    import adc_seq_pkg::*;
#(
    parameter int SAMPLE_W = 12,
    localparam int ACC_W   = SAMPLE_W + MAX_SHIFT,
    localparam int CNT_W   = MAX_SHIFT + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                add,
    input  logic [SAMPLE_W-1:0] data,
    input  logic [AVG_W-1:0]    code,
    output logic                last,
    output logic [SAMPLE_W-1:0] avg
);
    logic [ACC_W-1:0] acc_q;
    logic [CNT_W-1:0] cnt_q;
    logic [AVG_W-1:0] sh;
    logic [CNT_W-1:0] target;
    logic [ACC_W-1:0] scaled;

    assign sh     = avg_shift(code);
    assign target = CNT_W'(1) << sh;
    assign last   = (cnt_q + CNT_W'(1)) == target;
    assign scaled = acc_q >> sh;
    assign avg    = scaled[SAMPLE_W-1:0];

    // Running sum and sample count for the current group.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            acc_q <= '0;
            cnt_q <= '0;
        end else if (add) begin
            acc_q <= acc_q + ACC_W'(data);
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end
endmodule

// File: rtl/adc_result_bank.sv
// Result bank: one result register and valid flag per input, with a
// same-cycle read port whose strobe clears the flag of the addressed entry.
// Assumes: a store and a read on the same entry in one cycle keep the flag set.
module adc_result_bank #(
    parameter int NUM_IN   = 8,
    parameter int SAMPLE_W = 12,
    localparam int IDX_W   = $clog2(NUM_IN)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                st_en,
    input  logic [IDX_W-1:0]    st_idx,
    input  logic [SAMPLE_W-1:0] st_data,
    input  logic                rd_en,
    input  logic [IDX_W-1:0]    rd_idx,
    output logic [SAMPLE_W-1:0] rd_data,
    output logic [NUM_IN-1:0]   valid
);
    logic [SAMPLE_W-1:0] res_q [NUM_IN];

    for (genvar g = 0; g < NUM_IN; g++) begin : g_entry
        // Entry g: capture on store, clear its flag on read.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                res_q[g] <= '0;
                valid[g] <= 1'b0;
            end else if (st_en && st_idx == IDX_W'(g)) begin
                res_q[g] <= st_data;
                valid[g] <= 1'b1;
            end else if (rd_en && rd_idx == IDX_W'(g)) begin
                valid[g] <= 1'b0;
            end
        end
    end

    assign rd_data = res_q[rd_idx];
endmodule

// File: rtl/adc_step_seq.sv
// Top: multi-input conversion sequencer built from the divider, scan controller,
// averager and result bank. Assumes an engine that answers each request with one
// done pulse carrying a sample.
module adc_step_seq
    import adc_seq_pkg::*;
#(
    parameter int NUM_IN        = 8,
    parameter int DLY_W         = 8,
    parameter int SAMPLE_W      = 12,
    parameter int PRESC_W       = 16,
    parameter int PRESC_DEFAULT = 2400,
    parameter int PRESC_MIN     = 10,
    localparam int IDX_W        = $clog2(NUM_IN)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_IN-1:0]       cfg_en,
    input  logic [NUM_IN*DLY_W-1:0] cfg_open_dly,
    input  logic [NUM_IN*AVG_W-1:0] cfg_avg,
    input  logic                    presc_wr,
    input  logic [PRESC_W-1:0]      presc_val,
    output logic                    conv_pwr,
    output logic                    conv_tick,
    output logic [IDX_W-1:0]        conv_sel,
    output logic                    conv_req,
    input  logic                    conv_done,
    input  logic [SAMPLE_W-1:0]     conv_data,
    input  logic                    rd_en,
    input  logic [IDX_W-1:0]        rd_idx,
    output logic [SAMPLE_W-1:0]     rd_data,
    output logic [NUM_IN-1:0]       res_valid
);
    logic                acc_clr, acc_add, grp_last, st_en;
    logic [SAMPLE_W-1:0] avg_val;
    logic [AVG_W-1:0]    cur_code;
    logic [IDX_W-1:0]    st_idx;

    assign cur_code = cfg_avg[int'(conv_sel)*AVG_W +: AVG_W];
    assign st_idx   = conv_sel;

    adc_clk_div #(
        .PRESC_W(PRESC_W), .PRESC_DEFAULT(PRESC_DEFAULT), .PRESC_MIN(PRESC_MIN)
    ) div_i (
        .clk(clk), .rst_n(rst_n), .run(conv_pwr),
        .wr(presc_wr), .wdata(presc_val), .tick(conv_tick)
    );

    adc_scan_ctrl #(.NUM_IN(NUM_IN), .DLY_W(DLY_W)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .en(cfg_en), .dly_flat(cfg_open_dly),
        .tick(conv_tick), .done(conv_done), .grp_last(grp_last),
        .sel(conv_sel), .req(conv_req), .pwr(conv_pwr),
        .acc_clr(acc_clr), .acc_add(acc_add), .st_en(st_en)
    );

    adc_avg_acc #(.SAMPLE_W(SAMPLE_W)) avg_i (
        .clk(clk), .rst_n(rst_n), .clr(acc_clr), .add(acc_add),
        .data(conv_data), .code(cur_code), .last(grp_last), .avg(avg_val)
    );

    adc_result_bank #(.NUM_IN(NUM_IN), .SAMPLE_W(SAMPLE_W)) bank_i (
        .clk(clk), .rst_n(rst_n), .st_en(st_en), .st_idx(st_idx),
        .st_data(avg_val), .rd_en(rd_en), .rd_idx(rd_idx),
        .rd_data(rd_data), .valid(res_valid)
    );
endmodule

// File: rtl/adc_step_seq_chk.sv
// Checker for adc_step_seq: temporal properties over ports and the store strobe.
// Assumes done pulses only while a request is outstanding.
module adc_step_seq_chk #(
    parameter int NUM_IN = 8,
    parameter int IDX_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_IN-1:0] cfg_en,
    input logic              conv_pwr,
    input logic              conv_tick,
    input logic              conv_req,
    input logic              conv_done,
    input logic [IDX_W-1:0]  conv_sel,
    input logic              rd_en,
    input logic [IDX_W-1:0]  rd_idx,
    input logic [NUM_IN-1:0] res_valid,
    input logic              st_en,
    input logic [IDX_W-1:0]  st_idx
);
    // R3
    req_needs_pwr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req |-> conv_pwr);

    // R3
    off_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_en == '0) |=> !conv_pwr);

    // R2
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_tick |=> !conv_tick);

    // R8
    sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_req && !conv_done && cfg_en != '0) |=> (conv_req && $stable(conv_sel)));

    // R7
    read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !(st_en && st_idx == rd_idx)) |=> !res_valid[$past(rd_idx)]);
endmodule

bind adc_step_seq adc_step_seq_chk #(.NUM_IN(NUM_IN), .IDX_W(IDX_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .conv_pwr(conv_pwr),
    .conv_tick(conv_tick), .conv_req(conv_req), .conv_done(conv_done),
    .conv_sel(conv_sel), .rd_en(rd_en), .rd_idx(rd_idx),
    .res_valid(res_valid), .st_en(st_en), .st_idx(st_idx)
);

// File: tb/adc_step_seq_tb_top.sv
// Bench for adc_step_seq: engine model with random latency and data, directed and
// random configurations, expected averages and scan order computed in the bench.
module adc_step_seq_tb_top;
    localparam int N  = 8;
    localparam int DW = 8;
    localparam int SW = 12;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    cfg_en = '0;
    logic [N*DW-1:0] cfg_open_dly = '0;
    logic [N*3-1:0]  cfg_avg = '0;
    logic            presc_wr = 1'b0;
    logic [15:0]     presc_val = '0;
    logic            conv_pwr, conv_tick, conv_req;
    logic [2:0]      conv_sel;
    logic            conv_done = 1'b0;
    logic [SW-1:0]   conv_data = '0;
    logic            rd_en = 1'b0;
    logic [2:0]      rd_idx = '0;
    logic [SW-1:0]   rd_data;
    logic [N-1:0]    res_valid;

    always #4 clk = ~clk;

    adc_step_seq dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_open_dly(cfg_open_dly),
        .cfg_avg(cfg_avg), .presc_wr(presc_wr), .presc_val(presc_val),
        .conv_pwr(conv_pwr), .conv_tick(conv_tick), .conv_sel(conv_sel),
        .conv_req(conv_req), .conv_done(conv_done), .conv_data(conv_data),
        .rd_en(rd_en), .rd_idx(rd_idx), .rd_data(rd_data), .res_valid(res_valid)
    );

    int checks = 0;
    int fails  = 0;
    int b_dly[N];
    int b_avg[N];
    int exp_sum[N];
    int exp_n[N];
    int exp_res[N];
    bit pend[N];
    bit fullscale = 1'b0;
    int order_log[64];
    int nlog = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int eff_shift(input int code);
        return (code > 4) ? 4 : code;
    endfunction

    function automatic int next_en(input int prev, input logic [N-1:0] mask);
        for (int k = 1; k <= N; k++) begin
            if (mask[(prev + k) % N]) return (prev + k) % N;
        end
        return prev;
    endfunction

    // Engine model: answers an outstanding request after a random latency.
    initial begin
        int ch, lat, smp;
        bit ok;
        forever begin
            @(negedge clk);
            if (conv_req) begin
                ch  = int'(conv_sel);
                lat = $urandom_range(0, 3);
                ok  = 1'b1;
                for (int i = 0; i < lat; i++) begin
                    @(negedge clk);
                    if (!conv_req) ok = 1'b0;
                end
                if (ok && conv_req) begin
                    // R8: selection held for the whole group
                    check(int'(conv_sel) == ch, "R8", int'(conv_sel), ch);
                    smp = fullscale ? 4095 : int'($urandom_range(0, 4095));
                    conv_data = SW'(smp);
                    conv_done = 1'b1;
                    exp_sum[ch] += smp;
                    exp_n[ch]++;
                    if (exp_n[ch] == (1 << eff_shift(b_avg[ch]))) begin
                        exp_res[ch] = exp_sum[ch] >> eff_shift(b_avg[ch]);
                        pend[ch]    = 1'b1;
                        exp_sum[ch] = 0;
                        exp_n[ch]   = 0;
                    end
                    @(negedge clk);
                    conv_done = 1'b0;
                end
            end
        end
    end

    // Order and settling monitor: logs each group start and counts ticks before it.
    initial begin
        int ticks;
        bit prev_req;
        ticks = 0;
        prev_req = 1'b0;
        forever begin
            @(negedge clk);
            if (!conv_pwr) begin
                ticks = 0;
                prev_req = 1'b0;
            end else begin
                if (!conv_req && conv_tick) ticks++;
                if (conv_req && !prev_req) begin
                    if (nlog < 64) order_log[nlog] = int'(conv_sel);
                    nlog++;
                    // R5: settling count honoured (a tick in the store cycle may add one)
                    check(ticks >= b_dly[conv_sel] && ticks <= b_dly[conv_sel] + 1,
                          "R5", ticks, b_dly[conv_sel]);
                    ticks = 0;
                end
                prev_req = conv_req;
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    task automatic apply_cfg();
        for (int c = 0; c < N; c++) begin
            cfg_open_dly[c*DW +: DW] = DW'(b_dly[c]);
            cfg_avg[c*3 +: 3]        = 3'(b_avg[c]);
        end
    endtask

    task automatic write_presc(input int v);
        @(negedge clk);
        presc_wr  = 1'b1;
        presc_val = 16'(v);
        @(negedge clk);
        presc_wr  = 1'b0;
    endtask

    task automatic measure_period(output int n);
        n = 0;
        for (int rep = 0; rep < 2; rep++) begin
            do @(negedge clk); while (!conv_tick);
            n = 0;
            do begin @(negedge clk); n++; end while (!conv_tick);
        end
    endtask

    task automatic stop_scan();
        do begin @(negedge clk); #2; end while (conv_done);
        cfg_en = '0;
        for (int c = 0; c < N; c++) begin exp_sum[c] = 0; exp_n[c] = 0; end
        @(negedge clk); #1;
        // R3: disabled inputs power the converter down at once
        check(conv_pwr == 1'b0, "R3", int'(conv_pwr), 0);
        check(conv_req == 1'b0, "R3", int'(conv_req), 0);
    endtask

    task automatic read_all();
        for (int c = 0; c < N; c++) begin
            @(negedge clk);
            rd_en = 1'b1;
            rd_idx = 3'(c);
            #1;
            // R7: flag reflects whether a new result was stored
            check(res_valid[c] == pend[c], "R7", int'(res_valid[c]), int'(pend[c]));
            // R6: stored value is the truncated average of the group
            if (pend[c]) check(int'(rd_data) == exp_res[c], "R6", int'(rd_data), exp_res[c]);
            @(negedge clk);
            rd_en = 1'b0;
            #1;
            // R7: read clears the flag
            check(res_valid[c] == 1'b0, "R7", int'(res_valid[c]), 0);
            pend[c] = 1'b0;
        end
    endtask

    task automatic run_phase(input logic [N-1:0] mask, input int groups);
        int exp_ch, guard;
        apply_cfg();
        @(negedge clk);
        nlog = 0;
        cfg_en = mask;
        guard = 0;
        while (nlog < groups && guard < 30000) begin @(negedge clk); guard++; end
        stop_scan();
        exp_ch = N - 1;
        for (int i = 0; i < groups && i < 64; i++) begin
            exp_ch = next_en(exp_ch, mask);
            // R4: ascending scan with wrap
            check(order_log[i] == exp_ch, "R4", order_log[i], exp_ch);
        end
        read_all();
    endtask

    initial begin
        int per;
        void'($urandom(32'd20240611));
        for (int c = 0; c < N; c++) begin
            b_dly[c] = 0; b_avg[c] = 0; exp_sum[c] = 0; exp_n[c] = 0;
            exp_res[c] = 0; pend[c] = 1'b0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        // R1: reset state
        check(conv_pwr == 1'b0, "R1", int'(conv_pwr), 0);
        check(conv_req == 1'b0, "R1", int'(conv_req), 0);
        check(res_valid == '0, "R1", int'(res_valid), 0);
        rst_n = 1'b1;

        // R1: default divisor observed once powered
        apply_cfg();
        cfg_en = 8'h01;
        measure_period(per);
        check(per == 2400, "R1", per, 2400);
        // R2: low writes clamp to the minimum
        write_presc(3);
        measure_period(per);
        check(per == 10, "R2", per, 10);
        write_presc(25);
        measure_period(per);
        check(per == 25, "R2", per, 25);
        stop_scan();
        read_all();

        // Directed: sparse mask with varied settling and averaging
        write_presc(12);
        b_dly[2] = 3; b_avg[2] = 1;
        b_dly[5] = 0; b_avg[5] = 3;
        b_dly[7] = 5; b_avg[7] = 2;
        run_phase(8'b1010_0100, 9);

        // Directed: single highest input wraps to itself
        b_dly[7] = 2; b_avg[7] = 4;
        run_phase(8'b1000_0000, 3);

        // Directed: codes above 4 behave as sixteen samples (R6)
        b_avg[0] = 5; b_avg[1] = 6; b_avg[3] = 7;
        b_dly[0] = 1; b_dly[1] = 0; b_dly[3] = 4;
        run_phase(8'b0000_1011, 6);

        // R9: full-scale samples over sixteen-sample groups
        fullscale = 1'b1;
        for (int c = 0; c < N; c++) begin b_avg[c] = 4; b_dly[c] = 0; end
        run_phase(8'hFF, 8);
        fullscale = 1'b0;

        // Random configurations
        for (int p = 0; p < 5; p++) begin
            logic [N-1:0] mask;
            mask = N'($urandom_range(1, 255));
            for (int c = 0; c < N; c++) begin
                b_dly[c] = $urandom_range(0, 4);
                b_avg[c] = $urandom_range(0, 7);
            end
            write_presc($urandom_range(10, 20));
            run_phase(mask, 10);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule